// File: doc/BRIEF.md
# Host Wake Access Handshake Controller

This block is the device-side general-purpose control word that governs the power state of an internal processor domain. The host writes the word to do two things: mark the device as initialised and fully operational, and request that the internal domain be woken and kept awake while the host touches internal resources. When the host reads the word it sees the domain's clock-ready and going-to-sleep indications, the current power-save type, the live level of the hardware radio-kill switch and the board configuration straps.

A programmable wake delay stands in for real clock and analog power sequencing. The internal domain asks to sleep through `sleep_req`. It is let go only when the host holds no access request. It then shows a fixed going-to-sleep window before it drops clock-ready. The host cannot raise a new access request during that window. A software reset returns the operational state to power-off.

Top module: `wake_ctl_top`

## Requirements
- R1: A host write (`wr_en`=1) changes only bit 2 (init-done) and bit 3 (access request) of `status_word`. Writes to any other bit have no effect, and both bits reset to 0.
- R2: Bit 0 (clock-ready) is 0 after reset and stays 0 while bit 2 is 0. Clearing bit 2 drops clock-ready on the same edge that stores the write.
- R3: After the edge that sets init-done from power-off, clock-ready rises exactly WAKE_DLY cycles later (default 8). From the asleep state, an edge that stores an access request with init-done set starts the same WAKE_DLY wake.
- R4: With clock-ready 1, `sleep_req` 1 and no access request held, bit 4 (going-to-sleep) is 1 for exactly DRAIN_LEN cycles (default 4) while clock-ready stays 1. Then both fall together.
- R5: While an access request is held, the domain does not start to sleep. A write of 1 to bit 3 while bit 4 is 1 is refused and bit 3 stays 0.
- R6: Bits 26:24 give the power-save type: 001 while asleep after a sleep sequence, 010 while clock-ready is 1 and the radio-kill level is 1, 011 once `sleep_req` is seen during a wake, and 000 otherwise. 011 overrides all others and holds until a reset.
- R7: Bit 27 follows `rfkill_level` and bits 9:6 follow `straps[3:0]` combinationally in every state.
- R8: `dom_pwr_en` is 1 exactly while the domain is waking, awake or going to sleep. It is 0 in power-off and asleep.
- R9: Bits 1, 5, 10 to 23 and 28 to 31 of `status_word` always read 0.
- R10: `sw_rst` (or `rst`) clears init-done, the access request and a latched error, and returns the domain to power-off on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_rst | input | 1 | Software reset of the operational state |
| wr_en | input | 1 | Host write strobe for the control word |
| wr_data | input | 32 | Host write data |
| sleep_req | input | 1 | Sleep request from the internal domain |
| rfkill_level | input | 1 | Live radio-kill switch level |
| straps | input | 4 | Board configuration straps |
| status_word | output | 32 | Readable control and status word |
| dom_pwr_en | output | 1 | Power enable for the internal domain |

## Verification
A wrong internal state shows up at once in the port word. The state machine drives clock-ready, going-to-sleep, the power-save type and `dom_pwr_en` directly from state, so a bad transition changes one of them in the very next cycle. A wrong count in the wake or drain counter does not show until the end of the window, when clock-ready rises or falls one or more cycles early or late. The bench therefore compares every field against a behavioural model on every cycle rather than only at the end of a sequence.

// File: rtl/wake_ctl_pkg.sv
package wake_ctl_pkg;

    localparam int WORD_W = 32;

    localparam int BIT_CLK_RDY = 0;
    localparam int BIT_INIT    = 2;
    localparam int BIT_ACC_REQ = 3;
    localparam int BIT_GOING   = 4;
    localparam int STRAP_LO    = 6;
    localparam int STRAP_W     = 4;
    localparam int PST_LO      = 24;
    localparam int PST_W       = 3;
    localparam int BIT_RFKILL  = 27;

    localparam logic [WORD_W-1:0] HOST_MASK =
        (WORD_W'(1) << BIT_INIT) | (WORD_W'(1) << BIT_ACC_REQ);

    typedef enum logic [2:0] {
        ST_OFF    = 3'd0,
        ST_WAKING = 3'd1,
        ST_AWAKE  = 3'd2,
        ST_DRAIN  = 3'd3,
        ST_ASLEEP = 3'd4
    } dom_state_e;

    typedef enum logic [PST_W-1:0] {
        PST_NONE  = 3'b000,
        PST_MAC   = 3'b001,
        PST_RADIO = 3'b010,
        PST_ERR   = 3'b011
    } pst_e;

    typedef struct packed {
        logic               clk_rdy;
        logic               going;
        pst_e               pst;
        logic               rfkill;
        logic [STRAP_W-1:0] straps;
    } ro_fields_t;

    function automatic logic [WORD_W-1:0] pack_word(
        input logic [WORD_W-1:0] host_bits,
        input ro_fields_t        ro
    );
        logic [WORD_W-1:0] w;
        w = host_bits & HOST_MASK;
        w[BIT_CLK_RDY] = ro.clk_rdy;
        w[BIT_GOING]   = ro.going;
        w[STRAP_LO +: STRAP_W] = ro.straps;
        w[PST_LO +: PST_W] = ro.pst;
        w[BIT_RFKILL] = ro.rfkill;
        return w;
    endfunction

endpackage

// File: rtl/wake_ctl_regs.sv
module wake_ctl_regs
    import wake_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sw_rst,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              going,
    output logic [WORD_W-1:0] host_q,
    output logic              init_nxt,
    output logic              req_nxt
);
    logic [WORD_W-1:0] wmask;
    logic [WORD_W-1:0] host_d;

    always_comb begin
        wmask = HOST_MASK;
        if (going) begin
            wmask[BIT_ACC_REQ] = 1'b0;
        end
        host_d = host_q;
        if (wr_en) begin
            host_d = (host_q & ~wmask) | (wr_data & wmask);
            if (going) begin
                host_d[BIT_ACC_REQ] = 1'b0;
            end
        end
        if (rst || sw_rst) begin
            host_d = '0;
        end
    end

    assign init_nxt = host_d[BIT_INIT];
    assign req_nxt  = host_d[BIT_ACC_REQ];

    always_ff @(posedge clk) begin
        host_q <= host_d & HOST_MASK;
    end
endmodule

// File: rtl/wake_ctl_fsm.sv
module wake_ctl_fsm
    import wake_ctl_pkg::*;
#(
    parameter int WAKE_DLY  = 8,
    parameter int DRAIN_LEN = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sw_rst,
    input  logic       init_nxt,
    input  logic       req_nxt,
    input  logic       sleep_req,
    output dom_state_e state,
    output logic       err_q
);
    localparam int MAXC  = (WAKE_DLY > DRAIN_LEN) ? WAKE_DLY : DRAIN_LEN;
    localparam int CNT_W = $clog2(MAXC + 1);
    localparam logic [CNT_W-1:0] WAKE_LD  = CNT_W'(WAKE_DLY - 1);
    localparam logic [CNT_W-1:0] DRAIN_LD = CNT_W'(DRAIN_LEN - 1);

    dom_state_e       st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             err_d;

    always_comb begin
        st_d  = state;
        cnt_d = cnt_q;
        err_d = err_q | (sleep_req && state == ST_WAKING);
        if (!init_nxt) begin
            st_d = ST_OFF;
        end else begin
            unique case (state)
                ST_OFF: begin
                    st_d  = ST_WAKING;
                    cnt_d = WAKE_LD;
                end
                ST_WAKING: begin
                    if (cnt_q == '0) st_d = ST_AWAKE;
                    else             cnt_d = cnt_q - 1'b1;
                end
                ST_AWAKE: begin
                    if (sleep_req && !req_nxt) begin
                        st_d  = ST_DRAIN;
                        cnt_d = DRAIN_LD;
                    end
                end
                ST_DRAIN: begin
                    if (cnt_q == '0) st_d = ST_ASLEEP;
                    else             cnt_d = cnt_q - 1'b1;
                end
                ST_ASLEEP: begin
                    if (req_nxt) begin
                        st_d  = ST_WAKING;
                        cnt_d = WAKE_LD;
                    end
                end
                default: st_d = ST_OFF;
            endcase
        end
        if (rst || sw_rst) begin
            st_d  = ST_OFF;
            cnt_d = '0;
            err_d = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        state <= st_d;
        cnt_q <= cnt_d;
        err_q <= err_d;
    end
endmodule

// File: rtl/wake_ctl_status.sv
module wake_ctl_status
    import wake_ctl_pkg::*;
(
    input  dom_state_e         state,
    input  logic               err_q,
    input  logic [WORD_W-1:0]  host_q,
    input  logic               rfkill_level,
    input  logic [STRAP_W-1:0] straps,
    output logic [WORD_W-1:0]  status_word,
    output logic               dom_pwr_en,
    output logic               going
);
    ro_fields_t ro;

    always_comb begin
        ro.clk_rdy = (state == ST_AWAKE) || (state == ST_DRAIN);
        ro.going   = (state == ST_DRAIN);
        ro.rfkill  = rfkill_level;
        ro.straps  = straps;
        if (err_q)                        ro.pst = PST_ERR;
        else if (state == ST_ASLEEP)      ro.pst = PST_MAC;
        else if (ro.clk_rdy && rfkill_level) ro.pst = PST_RADIO;
        else                              ro.pst = PST_NONE;
    end

    assign status_word = pack_word(host_q, ro);
    assign going       = ro.going;
    assign dom_pwr_en  = (state == ST_WAKING) || ro.clk_rdy;
endmodule

// File: rtl/wake_ctl_top.sv
module wake_ctl_top
    import wake_ctl_pkg::*;
#(
    parameter int WAKE_DLY  = 8,
    parameter int DRAIN_LEN = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        sw_rst,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    input  logic        sleep_req,
    input  logic        rfkill_level,
    input  logic [3:0]  straps,
    output logic [31:0] status_word,
    output logic        dom_pwr_en
);
    logic [WORD_W-1:0] host_q;
    logic              init_nxt, req_nxt, going, err_q;
    dom_state_e        state;

    wake_ctl_regs u_regs (
        .clk(clk), .rst(rst), .sw_rst(sw_rst), .wr_en(wr_en),
        .wr_data(wr_data), .going(going), .host_q(host_q),
        .init_nxt(init_nxt), .req_nxt(req_nxt)
    );

    wake_ctl_fsm #(.WAKE_DLY(WAKE_DLY), .DRAIN_LEN(DRAIN_LEN)) u_fsm (
        .clk(clk), .rst(rst), .sw_rst(sw_rst), .init_nxt(init_nxt),
        .req_nxt(req_nxt), .sleep_req(sleep_req), .state(state),
        .err_q(err_q)
    );

    wake_ctl_status u_status (
        .state(state), .err_q(err_q), .host_q(host_q),
        .rfkill_level(rfkill_level), .straps(straps),
        .status_word(status_word), .dom_pwr_en(dom_pwr_en), .going(going)
    );
endmodule

// File: rtl/wake_ctl_chk.sv
module wake_ctl_chk #(
    parameter int DRAIN_LEN = 4
) (
    input logic        clk,
    input logic        rst,
    input logic        sw_rst,
    input logic [31:0] status_word,
    input logic        dom_pwr_en
);
    localparam int GW = $clog2(DRAIN_LEN + 2);
    logic [GW-1:0] g_cnt;

    always_ff @(posedge clk) begin
        if (rst || sw_rst)       g_cnt <= '0;
        else if (status_word[4]) g_cnt <= g_cnt + 1'b1;
        else                     g_cnt <= '0;
    end

    p_rdy_needs_init_r2: assert property (@(posedge clk) disable iff (rst || sw_rst)
        status_word[0] |-> status_word[2]);

    p_going_len_r4: assert property (@(posedge clk) disable iff (rst || sw_rst)
        ($fell(status_word[4]) && status_word[2] && g_cnt != '0)
            |-> (g_cnt == GW'(DRAIN_LEN) && !status_word[0]));

    p_no_req_going_r5: assert property (@(posedge clk) disable iff (rst || sw_rst)
        status_word[4] |-> !status_word[3]);

    p_pwr_when_rdy_r8: assert property (@(posedge clk) disable iff (rst || sw_rst)
        status_word[0] |-> dom_pwr_en);

    p_reserved_zero_r9: assert property (@(posedge clk) disable iff (rst)
        (status_word & 32'hF0FF_FC22) == 32'h0);

    p_off_after_swrst_r10: assert property (@(posedge clk) disable iff (rst)
        sw_rst |=> (!dom_pwr_en && status_word[3:0] == 4'h0));
endmodule

bind wake_ctl_top wake_ctl_chk #(.DRAIN_LEN(DRAIN_LEN)) u_chk (
    .clk(clk), .rst(rst), .sw_rst(sw_rst),
    .status_word(status_word), .dom_pwr_en(dom_pwr_en)
);

// File: tb/test_wake_ctl_top.sv
module test_wake_ctl_top;
    localparam int D = 8;
    localparam int L = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sw_rst = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        sleep_req = 1'b0;
    logic        rfkill_level = 1'b0;
    logic [3:0]  straps = 4'h0;
    logic [31:0] status_word;
    logic        dom_pwr_en;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // model: 0 off, 1 waking, 2 awake, 3 drain, 4 asleep
    int m_mode = 0, m_cnt = 0;
    bit m_init = 0, m_req = 0, m_err = 0;

    wake_ctl_top #(.WAKE_DLY(D), .DRAIN_LEN(L)) i_wake_ctl_top (
        .clk(clk), .rst(rst), .sw_rst(sw_rst), .wr_en(wr_en),
        .wr_data(wr_data), .sleep_req(sleep_req),
        .rfkill_level(rfkill_level), .straps(straps),
        .status_word(status_word), .dom_pwr_en(dom_pwr_en)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        bit going, ni, nr;
        going = (m_mode == 3);
        ni = wr_en ? wr_data[2] : m_init;
        nr = wr_en ? (wr_data[3] && !going) : m_req;
        if (rst || sw_rst) begin
            m_init = 0; m_req = 0; m_err = 0; m_mode = 0; m_cnt = 0;
        end else begin
            if (sleep_req && m_mode == 1) m_err = 1;
            if (!ni) m_mode = 0;
            else case (m_mode)
                0: begin m_mode = 1; m_cnt = D - 1; end
                1: if (m_cnt == 0) m_mode = 2; else m_cnt--;
                2: if (sleep_req && !nr) begin m_mode = 3; m_cnt = L - 1; end
                3: if (m_cnt == 0) m_mode = 4; else m_cnt--;
                4: if (nr) begin m_mode = 1; m_cnt = D - 1; end
                default: m_mode = 0;
            endcase
            m_init = ni; m_req = nr;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s t=%0t actual=%0h expected=%0h", tag, $time, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !done) begin
            bit rdy;
            int pst;
            rdy = (m_mode == 2 || m_mode == 3);
            if (m_err) pst = 3;
            else if (m_mode == 4) pst = 1;
            else if (rdy && rfkill_level) pst = 2;
            else pst = 0;
            chk("R1 init bit", int'(status_word[2]), int'(m_init));
            chk("R5 req bit", int'(status_word[3]), int'(m_req));
            chk("R2/R3 clock-ready", int'(status_word[0]), int'(rdy));
            chk("R4 going-to-sleep", int'(status_word[4]), int'(m_mode == 3));
            chk("R6 power-save type", int'(status_word[26:24]), pst);
            chk("R7 rfkill", int'(status_word[27]), int'(rfkill_level));
            chk("R7 straps", int'(status_word[9:6]), int'(straps));
            chk("R8 pwr enable", int'(dom_pwr_en), int'(m_mode >= 1 && m_mode <= 3));
            chk("R9 reserved", int'(status_word & 32'hF0FF_FC22), 0);
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #5;
    endtask

    task automatic wr(input logic [31:0] d);
        wr_en = 1'b1; wr_data = d;
        cyc(1);
        wr_en = 1'b0; wr_data = '0;
    endtask

    initial begin
        #2000000;
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        cyc(3);
        rst = 1'b0;
        straps = 4'hA;
        cyc(3);                       // R2: stays off without init
        sleep_req = 1'b1; cyc(2); sleep_req = 1'b0;
        wr(32'h0000_0004);            // R3: init-done wake
        cyc(D + 2);
        rfkill_level = 1'b1; cyc(2);  // R6 radio type, R7
        rfkill_level = 1'b0;
        wr(32'h0000_000C);            // hold request
        sleep_req = 1'b1; cyc(6);     // R5: no sleep while held
        wr(32'h0000_0004);            // release: R4 drain
        sleep_req = 1'b0;
        cyc(1);
        wr(32'h0000_000C);            // R5: refused while going
        cyc(L + 2);                   // asleep, R6 type 001
        wr(32'hFFFF_FFFF);            // R1: only bits 2,3; R3 wake from asleep
        cyc(2);
        sleep_req = 1'b1; cyc(1); sleep_req = 1'b0; // R6 error latch
        cyc(D + 2);
        straps = 4'h5;
        sw_rst = 1'b1; cyc(1); sw_rst = 1'b0;       // R10
        cyc(2);
        wr(32'h0000_0004); cyc(D + 2);
        sleep_req = 1'b1; cyc(2);
        wr(32'h0000_0000);            // R2: clear init mid-drain
        sleep_req = 1'b0;
        cyc(3);
        wr(32'h0000_000C); cyc(3);
        sw_rst = 1'b1; cyc(1); sw_rst = 1'b0;       // R10 during wake
        cyc(3);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule